// File: doc/BRIEF.md
# Program Request Error Checker

This block sits between a flash controller's write path and the memory array model. It checks every program request before the request reaches the array. A request names a byte address and an access size. The block tests that request against four rules: the configured program width, the 16-byte row boundary, per-sector write protection, and whether programming mode is enabled. A request that passes all four rules is handed to the array on a valid/ready output stream, and the block reports busy until the array returns a done strobe. A request that breaks any rule is dropped. Each broken rule leaves its own sticky flag in a status word, and software clears these flags by writing ones.

Requests arrive on a valid/ready input stream. The block accepts a request only while no operation is in flight, so a caller holds its request until `req_ready` is high. On the output stream, `fwd_valid` stays high with a stable payload until the array raises `fwd_ready`. Two enables gate the summary error flag and the end-of-operation flag, and they also gate the interrupt line.

Top module: `prog_req_checker`

## Requirements
- R1: Sizes are encoded as 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes and 11 = 8 bytes. An accepted request whose `req_size` differs from `psize_cfg` sets status bit 6 (width error).
- R2: An accepted request whose row offset (address bits 3:0) plus its byte count exceeds 16 sets status bit 5 (row error). A request that ends exactly on the row end is legal.
- R3: The sector is address bits 17:14. An accepted request sets status bit 4 (protection error) when `wp_mask` holds 0 for that sector, or when the sector index is 12 or above.
- R4: An accepted request made while `pg_en` is 0 sets status bit 7 (sequence error).
- R5: Status bits 7:4, 1 and 0 are sticky. A write with `sr_wr` high clears exactly the bits that are 1 in `sr_wdata`, and leaves every other flag unchanged.
- R6: The four rules are decoded independently, so several error bits can be set by one request. A request that fails any rule is not forwarded and leaves busy (bit 16) at 0.
- R7: A rejected request sets status bit 1 (operation error) only when `err_ie` is 1.
- R8: A clean accepted request sets busy (bit 16) one cycle after acceptance. Busy clears one cycle after a `done_strobe` that arrives once the request has been handed over. At that point status bit 0 (end of operation) is set, but only when `done_ie` is 1. A done strobe that arrives while idle, or before the handover, has no effect.
- R9: `irq` is high exactly when (bit 1 and `err_ie`) or (bit 0 and `done_ie`) holds.
- R10: `req_ready` is low while busy, so a request offered then is not taken. `fwd_valid` holds with stable address and size until `fwd_ready`, and each clean request is forwarded exactly once.
- R11: After reset the status word is 0, `req_ready` is 1, and `irq` and `fwd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Program request offered |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | 18 | Byte address of the request |
| req_size | input | 2 | Access size code |
| psize_cfg | input | 2 | Configured program width code |
| pg_en | input | 1 | Programming mode enabled |
| err_ie | input | 1 | Error interrupt enable |
| done_ie | input | 1 | End-of-operation interrupt enable |
| wp_mask | input | 12 | Per-sector unprotect bits (0 = protected) |
| fwd_valid | output | 1 | Clean request offered to the array |
| fwd_ready | input | 1 | Array takes the forwarded request |
| fwd_addr | output | 18 | Forwarded address |
| fwd_size | output | 2 | Forwarded size code |
| done_strobe | input | 1 | Array finished the current operation |
| sr_wr | input | 1 | Status write strobe |
| sr_wdata | input | 32 | Write-one-to-clear data |
| status | output | 32 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
The bench first sends clean requests, including an 8-byte write ending exactly on a row end and a write into the last legal sector. These show that legal traffic is forwarded once and raises busy. It then breaks each rule on its own, to show that each cause maps to its own flag. It also breaks two rules together, to show that the causes are decoded independently rather than by priority. Runs with each enable off separate flag setting from interrupt gating. A stalled output stream with an early done strobe, and a request offered while busy, show the handshake rules and that an operation cannot finish before its handover.

// File: rtl/prq_pkg.sv
package prq_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_DBL  = 2'b11
  } psz_e;

  localparam int BIT_BUSY  = 16;
  localparam int BIT_ERR_H = 7;
  localparam int BIT_ERR_L = 4;
  localparam int BIT_OPERR = 1;
  localparam int BIT_EOP   = 0;

  typedef struct packed {
    logic seq;
    logic par;
    logic aln;
    logic prot;
  } err_t;
endpackage

// File: rtl/prq_rules.sv
module prq_rules
  import prq_pkg::*;
#(
  parameter int ROW_W       = 4,
  parameter int SEC_W       = 4,
  parameter int NUM_SECTORS = 12
) (
  input  logic [ROW_W-1:0]       row_off,
  input  logic [SEC_W-1:0]       sec_idx,
  input  logic [1:0]             size,
  input  logic [1:0]             psize,
  input  logic                   pg_en,
  input  logic [NUM_SECTORS-1:0] wp_mask,
  output err_t                   errs,
  output logic                   any_err
);
  localparam int SPAN_W    = ROW_W + 4;
  localparam int ROW_BYTES = 1 << ROW_W;
  localparam int SEC_SLOTS = 1 << SEC_W;

  logic [SPAN_W-1:0]    end_pos;
  logic [SEC_SLOTS-1:0] locked;

  // sectors past the populated range count as locked
  for (genvar i = 0; i < SEC_SLOTS; i++) begin : g_lock
    if (i < NUM_SECTORS) begin : g_real
      assign locked[i] = ~wp_mask[i];
    end else begin : g_void
      assign locked[i] = 1'b1;
    end
  end

  assign end_pos = SPAN_W'(row_off) + (SPAN_W'(1) << size);

  always_comb begin
    errs.seq  = ~pg_en;
    errs.par  = (psz_e'(size) != psz_e'(psize));
    errs.aln  = (end_pos > SPAN_W'(ROW_BYTES));
    errs.prot = locked[sec_idx];
    any_err   = |errs;
  end
endmodule

// File: rtl/prq_status.sv
module prq_status
  import prq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rej,
  input  err_t       errs,
  input  logic       err_ie,
  input  logic       fin,
  input  logic       done_ie,
  input  logic       clr_en,
  input  logic [5:0] clr_bits,
  output logic [3:0] err_flags,
  output logic       op_flag,
  output logic       eop_flag
);
  logic [5:0] clr;
  assign clr = clr_en ? clr_bits : 6'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flags <= '0;
      op_flag   <= 1'b0;
      eop_flag  <= 1'b0;
    end else begin
      err_flags <= (err_flags & ~clr[5:2]) | (rej ? errs : 4'b0);
      op_flag   <= (op_flag & ~clr[1]) | (rej & err_ie);
      eop_flag  <= (eop_flag & ~clr[0]) | (fin & done_ie);
    end
  end

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((err_flags & $past(err_flags)) == $past(err_flags))); // R5
  AST_OPERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_flag) |-> $past(err_ie)); // R7
  AST_EOP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eop_flag) |-> $past(done_ie)); // R8
endmodule

// File: rtl/prq_issue.sv
module prq_issue #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              any_err,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [1:0]        fwd_size,
  input  logic              done_strobe,
  output logic              busy,
  output logic              accept,
  output logic              fin
);
  assign req_ready = ~busy;
  assign accept    = req_valid & ~busy;
  // finish only once the request has left the output stage
  assign fin       = busy & ~fwd_valid & done_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      fwd_valid <= 1'b0;
      fwd_addr  <= '0;
      fwd_size  <= '0;
    end else if (accept && !any_err) begin
      busy      <= 1'b1;
      fwd_valid <= 1'b1;
      fwd_addr  <= req_addr;
      fwd_size  <= req_size;
    end else begin
      if (fwd_valid && fwd_ready) fwd_valid <= 1'b0;
      if (fin) busy <= 1'b0;
    end
  end

  AST_REJECT_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && any_err) |=> (!busy && !fwd_valid)); // R6
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_strobe) |=> busy); // R10
  AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_addr) && $stable(fwd_size))); // R10
endmodule

// File: rtl/prog_req_checker.sv
module prog_req_checker
  import prq_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int ROW_W       = 4,
  parameter int SEC_LSB     = 14,
  parameter int NUM_SECTORS = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [1:0]             req_size,
  input  logic [1:0]             psize_cfg,
  input  logic                   pg_en,
  input  logic                   err_ie,
  input  logic                   done_ie,
  input  logic [NUM_SECTORS-1:0] wp_mask,
  output logic                   fwd_valid,
  input  logic                   fwd_ready,
  output logic [ADDR_W-1:0]      fwd_addr,
  output logic [1:0]             fwd_size,
  input  logic                   done_strobe,
  input  logic                   sr_wr,
  input  logic [31:0]            sr_wdata,
  output logic [31:0]            status,
  output logic                   irq
);
  localparam int SEC_W = $clog2(NUM_SECTORS);

  err_t       errs;
  logic       any_err, accept, fin, busy;
  logic [3:0] err_flags;
  logic       op_flag, eop_flag;
  logic       unused_wdata;

  assign unused_wdata = ^{sr_wdata[31:8], sr_wdata[3:2]};

  prq_rules #(.ROW_W(ROW_W), .SEC_W(SEC_W), .NUM_SECTORS(NUM_SECTORS)) u_rules (
    .row_off (req_addr[ROW_W-1:0]),
    .sec_idx (req_addr[SEC_LSB +: SEC_W]),
    .size    (req_size),
    .psize   (psize_cfg),
    .pg_en   (pg_en),
    .wp_mask (wp_mask),
    .errs    (errs),
    .any_err (any_err)
  );

  prq_issue #(.ADDR_W(ADDR_W)) u_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_size    (req_size),
    .any_err     (any_err),
    .fwd_valid   (fwd_valid),
    .fwd_ready   (fwd_ready),
    .fwd_addr    (fwd_addr),
    .fwd_size    (fwd_size),
    .done_strobe (done_strobe),
    .busy        (busy),
    .accept      (accept),
    .fin         (fin)
  );

  prq_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .rej       (accept & any_err),
    .errs      (errs),
    .err_ie    (err_ie),
    .fin       (fin),
    .done_ie   (done_ie),
    .clr_en    (sr_wr),
    .clr_bits  ({sr_wdata[BIT_ERR_H:BIT_ERR_L], sr_wdata[BIT_OPERR], sr_wdata[BIT_EOP]}),
    .err_flags (err_flags),
    .op_flag   (op_flag),
    .eop_flag  (eop_flag)
  );

  always_comb begin
    status                      = '0;
    status[BIT_BUSY]            = busy;
    status[BIT_ERR_H:BIT_ERR_L] = err_flags;
    status[BIT_OPERR]           = op_flag;
    status[BIT_EOP]             = eop_flag;
  end

  assign irq = (op_flag & err_ie) | (eop_flag & done_ie);

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status[BIT_OPERR] || status[BIT_EOP])); // R9
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !fwd_valid) |-> !status[BIT_BUSY]); // R11
endmodule

// File: tb/prog_req_checker_tb.sv
module prog_req_checker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [17:0] req_addr = '0;
  logic [1:0]  req_size = '0, psize_cfg = 2'd2;
  logic        pg_en = 1'b1, err_ie = 1'b1, done_ie = 1'b1;
  logic [11:0] wp_mask = 12'hFFF;
  logic        fwd_valid, fwd_ready = 1'b1;
  logic [17:0] fwd_addr;
  logic [1:0]  fwd_size;
  logic        done_strobe = 1'b0, sr_wr = 1'b0;
  logic [31:0] sr_wdata = '0, status;
  logic        irq;

  int          n_chk = 0, n_bad = 0;
  logic [31:0] exp_sr = '0;
  logic        exp_handed = 1'b0;
  logic [19:0] sb_q[$];

  always #2 clk = ~clk;

  prog_req_checker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .psize_cfg(psize_cfg), .pg_en(pg_en),
    .err_ie(err_ie), .done_ie(done_ie), .wp_mask(wp_mask), .fwd_valid(fwd_valid),
    .fwd_ready(fwd_ready), .fwd_addr(fwd_addr), .fwd_size(fwd_size),
    .done_strobe(done_strobe), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
    .status(status), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] model_err(logic [17:0] a, logic [1:0] sz);
    logic [3:0] e;
    int sec;
    sec  = int'(a[17:14]);
    e[3] = ~pg_en;
    e[2] = (sz != psize_cfg);
    e[1] = (int'(a[3:0]) + (1 << sz)) > 16;
    e[0] = (sec >= 12) ? 1'b1 : ~wp_mask[sec];
    return e;
  endfunction

  // monitor: pops expected forwards as the design hands them over
  always @(negedge clk) begin
    if (rst_n && fwd_valid && fwd_ready) begin
      if (sb_q.size() == 0) chk("R10 unexpected forward", {14'b0, fwd_addr}, 32'hFFFF_FFFF);
      else begin
        logic [19:0] it;
        it = sb_q.pop_front();
        chk("R10 forwarded item", {12'b0, fwd_size, fwd_addr}, {12'b0, it});
      end
    end
  end

  task automatic send(string tag, logic [17:0] a, logic [1:0] sz);
    logic [3:0] e;
    e = model_err(a, sz);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz;
    if (e == 4'b0) begin
      sb_q.push_back({sz, a});
      exp_sr[16] = 1'b1;
      exp_handed = fwd_ready;
    end else begin
      exp_sr[7:4] = exp_sr[7:4] | e;
      if (err_ie) exp_sr[1] = 1'b1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, status, exp_sr);
  endtask

  task automatic done_pulse(string tag);
    @(negedge clk);
    done_strobe = 1'b1;
    @(negedge clk);
    done_strobe = 1'b0;
    if (exp_sr[16] && exp_handed) begin
      exp_sr[16] = 1'b0;
      if (done_ie) exp_sr[0] = 1'b1;
    end
    chk(tag, status, exp_sr);
  endtask

  task automatic clear(string tag, logic [31:0] bits);
    @(negedge clk);
    sr_wr = 1'b1; sr_wdata = bits;
    @(negedge clk);
    sr_wr = 1'b0;
    exp_sr = exp_sr & ~(bits & 32'h0000_00F3);
    chk(tag, status, exp_sr);
  endtask

  task automatic chk_irq(string tag);
    chk(tag, {31'b0, irq}, {31'b0, (exp_sr[1] & err_ie) | (exp_sr[0] & done_ie)});
  endtask

  function automatic logic [17:0] at(int sec, int off);
    return 18'((sec << 14) | off);
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset status", status, 32'h0);
    chk("R11 reset ready/irq/fwd", {29'b0, req_ready, irq, fwd_valid}, 32'h4);

    // clean word request
    send("R8 busy after clean request", at(1, 8), 2'd2);
    chk("R10 ready low while busy", {31'b0, req_ready}, 32'h0);
    @(negedge clk);
    req_valid = 1'b1; req_addr = at(2, 0); req_size = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 request ignored while busy", status, exp_sr);
    done_pulse("R8 done sets eop, clears busy");
    chk_irq("R9 irq from eop");
    done_ie = 1'b0;
    @(negedge clk);
    chk_irq("R9 irq masked by done_ie");
    chk("R5 eop kept when enable drops", status, exp_sr);
    done_ie = 1'b1;
    clear("R5 clear eop", 32'h1);
    chk_irq("R9 irq low after clear");

    // width mismatch
    send("R1 width error", at(1, 0), 2'd1);
    chk("R6 rejected not busy", {31'b0, status[16]}, 32'h0);
    chk_irq("R9 irq from operr");
    clear("R5 clear width only", 32'h40);
    clear("R5 clear operr", 32'h02);

    // row boundary
    psize_cfg = 2'd3;
    send("R2 row overflow x64 off 12", at(2, 12), 2'd3);
    clear("R5 clear all", 32'hFFFF_FFFF);
    send("R2 x64 ends on row end", at(2, 8), 2'd3);
    done_pulse("R8 done x64");
    clear("R5 clear eop 2", 32'h1);
    psize_cfg = 2'd1;
    send("R2 x16 off 15 overflows", at(0, 15), 2'd1);
    clear("R5 clear all 2", 32'hF3);

    // protection
    psize_cfg = 2'd2;
    wp_mask = 12'hFF7;
    send("R3 protected sector 3", at(3, 4), 2'd2);
    clear("R5 clear 3", 32'hF3);
    wp_mask = 12'hFFF;
    send("R3 sector 12 locked", at(12, 0), 2'd2);
    clear("R5 clear 4", 32'hF3);
    send("R3 sector 11 open", at(11, 0), 2'd2);
    done_pulse("R8 done sector 11");
    clear("R5 clear eop 3", 32'h1);

    // sequence
    pg_en = 1'b0;
    send("R4 pg disabled", at(1, 0), 2'd2);
    clear("R5 clear 5", 32'hF3);
    send("R6 two causes at once", at(1, 0), 2'd0);
    clear("R5 clear 6", 32'hF3);
    pg_en = 1'b1;

    // enables off
    err_ie = 1'b0;
    send("R7 no operr when disabled", at(1, 0), 2'd3);
    chk_irq("R9 no irq without err_ie");
    clear("R5 clear 7", 32'hF3);
    err_ie = 1'b1;
    done_ie = 1'b0;
    send("R8 clean with done_ie off", at(4, 0), 2'd2);
    done_pulse("R8 no eop when disabled");
    chk_irq("R9 no irq done_ie off");
    done_ie = 1'b1;

    // stalled output stream
    fwd_ready = 1'b0;
    send("R10 stalled request busy", at(5, 4), 2'd2);
    repeat (3) begin
      @(negedge clk);
      chk("R10 fwd held", {13'b0, fwd_valid, fwd_addr}, {13'b0, 1'b1, at(5, 4)});
    end
    done_pulse("R8 done before handover ignored");
    @(posedge clk);
    #1 fwd_ready = 1'b1;
    exp_handed = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 fwd dropped after handshake", {31'b0, fwd_valid}, 32'h0);
    done_pulse("R8 done after handover");
    clear("R5 clear eop 4", 32'h1);

    done_pulse("R8 done while idle ignored");
    chk("R10 scoreboard drained", sb_q.size(), 32'h0);
    summary();
  end
endmodule